// File: doc/BRIEF.md
# Bit-Masked Camera PHY Control Register Bank

This block is a small bank of 32-bit control words on a simple register bus, used to steer the control pins of a camera receive PHY. Its outputs drive the lane enables, the forced-mode controls, the turnaround controls, the clock-invert selects and a test-port control group. It also offers one read-only status word, which shows the PHY's 8-bit test data output after it has been brought into the bus clock domain.

Every write carries its own mask in the upper halfword of the write data. Bit i+16 set means data bit i is loaded. Bit i+16 clear means bit i keeps its value. Software can therefore change one field, or even one bit, with a single store and no read-modify-write.

Reads are combinational from the address. They return the word's current value in the low halfword and zeros in the high halfword. Bits that hold no field are not stored, and they always read as zero.

Top module: `phy_ctrl_bank`

## Requirements
- R1: On a write to a mapped control word, each stored bit i whose enable bit i+16 of the write data is 1 takes the value of write data bit i at the next clock edge.
- R2: A stored bit whose enable bit i+16 is 0 keeps its old value. This includes a write whose whole upper halfword is zero.
- R3: The word at offset 0x6254 holds four 4-bit fields: receive lane enable in bits 3:0, force-receive-mode in bits 7:4, force-transmit-stop in bits 11:8 and turnaround disable in bits 15:12. Each field drives its own 4-bit output.
- R4: The word at offset 0x6224 stores a 4-bit turn request for port 0 in bits 3:0, the port 0 clock invert in bit 10 and the port 1 clock invert in bit 11. All of its other bits read as 0, so writing all ones reads back 0x0C0F.
- R5: The word at offset 0x6260 stores a 4-bit turn request for port 1 in bits 3:0, source select in bit 4, base direction in bit 5, clock enable in bit 6 and master/slave select in bit 7. Bits 15:8 read as 0.
- R6: The word at offset 0x6264 stores the 8-bit test data input in bits 7:0, test enable in bit 8, test clock in bit 9 and test clear in bit 10. Bits 15:11 read as 0.
- R7: After reset every stored control bit is 0, except the test clock (bit 9 of 0x6264), which is 1.
- R8: A read of a control word returns its stored value in bits 15:0 and zero in bits 31:16.
- R9: A write to an offset that maps no word changes no stored bit. A read from such an offset returns 0.
- R10: The word at offset 0xE2A4 is read-only: writes to it have no effect. Its bits 7:0 show the PHY test data output as sampled by two flops, so an input change appears on reads after the second clock edge. Its bits 31:8 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 16 | Byte offset of the addressed word |
| bus_wdata | input | 32 | Bits 31:16 are the write mask and bits 15:0 are the data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| test_dout_i | input | 8 | PHY test data output (asynchronous) |
| rx_lane_en_o | output | 4 | Receive lane enables |
| force_rx_o | output | 4 | Force-receive-mode per lane |
| force_stop_o | output | 4 | Force-transmit-stop per lane |
| turn_dis_o | output | 4 | Turnaround disable per lane |
| turn_req0_o | output | 4 | Turn request, port 0 |
| clk_inv0_o | output | 1 | Clock invert select, port 0 |
| clk_inv1_o | output | 1 | Clock invert select, port 1 |
| turn_req1_o | output | 4 | Turn request, port 1 |
| src_sel_o | output | 1 | Port 1 source select |
| base_dir_o | output | 1 | Port 1 base direction |
| clk_en_o | output | 1 | Port 1 clock enable |
| role_o | output | 1 | Port 1 master/slave select |
| test_din_o | output | 8 | Test port data input |
| test_en_o | output | 1 | Test port enable |
| test_clk_o | output | 1 | Test port clock |
| test_clr_o | output | 1 | Test port clear |

## Verification
A stored bit that goes wrong shows at once on its dedicated output pin. It also shows on the very next read of its word, because reads need no clock edge.

A mask applied wrongly may only show up later. It lets a neighbouring field drift, so the checks read the whole word back after partial writes and compare every field, not only the one that was targeted. An address decode that is wrong shows either as a foreign write corrupting a word or as nonzero data from an unmapped offset.

For the status word, both the lag and its length are checked. The value must still be old after one edge and new after the second.

// File: rtl/phy_ctrl_bank_pkg.sv
package phy_ctrl_bank_pkg;

  localparam int NUM_WORDS = 4;
  localparam int HALF_W    = 16;

  localparam logic [15:0] OFS_LANE   = 16'h6254;
  localparam logic [15:0] OFS_TURN0  = 16'h6224;
  localparam logic [15:0] OFS_PORT1  = 16'h6260;
  localparam logic [15:0] OFS_TEST   = 16'h6264;
  localparam logic [15:0] OFS_STATUS = 16'hE2A4;

  // index order inside the bank
  localparam int IDX_LANE  = 0;
  localparam int IDX_TURN0 = 1;
  localparam int IDX_PORT1 = 2;
  localparam int IDX_TEST  = 3;

  function automatic logic [15:0] word_offset(input int idx);
    case (idx)
      IDX_LANE:  return OFS_LANE;
      IDX_TURN0: return OFS_TURN0;
      IDX_PORT1: return OFS_PORT1;
      default:   return OFS_TEST;
    endcase
  endfunction

  // bits that really hold a field
  function automatic logic [15:0] word_impl(input int idx);
    case (idx)
      IDX_LANE:  return 16'hFFFF;
      IDX_TURN0: return 16'h0C0F;
      IDX_PORT1: return 16'h00FF;
      default:   return 16'h07FF;
    endcase
  endfunction

  // only the test clock comes out of reset high
  function automatic logic [15:0] word_reset(input int idx);
    return (idx == IDX_TEST) ? 16'h0200 : 16'h0000;
  endfunction

  // bit-masked update: en selects new data, otherwise old value stays
  function automatic logic [15:0] masked_merge(input logic [15:0] old_v,
                                               input logic [15:0] new_v,
                                               input logic [15:0] en);
    return (old_v & ~en) | (new_v & en);
  endfunction

endpackage

// File: rtl/phy_ctrl_bank_word.sv
module phy_ctrl_bank_word
  import phy_ctrl_bank_pkg::*;
#(
  parameter logic [15:0] IMPL = 16'hFFFF,
  parameter logic [15:0] RSTV = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wdata,
  output logic [15:0] q
);

  logic [15:0] wr_en_bits;
  logic [15:0] wr_val_bits;
  logic [15:0] q_next;

  assign wr_en_bits  = wdata[31:16];
  assign wr_val_bits = wdata[15:0];
  assign q_next      = masked_merge(q, wr_val_bits, wr_en_bits) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RSTV & IMPL;
    else if (wr_hit) q <= q_next;
  end

  // enabled, implemented bits follow the write data
  assert_enabled_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((q & $past(wr_en_bits) & IMPL) ==
                ($past(wr_val_bits) & $past(wr_en_bits) & IMPL)));

  // disabled bits are left alone
  assert_masked_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((q & ~$past(wr_en_bits)) == ($past(q) & ~$past(wr_en_bits))));

  // without a write the word never moves
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q));

endmodule

// File: rtl/phy_ctrl_bank_sync.sv
module phy_ctrl_bank_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/phy_ctrl_bank.sv
module phy_ctrl_bank
  import phy_ctrl_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TDO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [TDO_W-1:0]  test_dout_i,
  output logic [3:0]        rx_lane_en_o,
  output logic [3:0]        force_rx_o,
  output logic [3:0]        force_stop_o,
  output logic [3:0]        turn_dis_o,
  output logic [3:0]        turn_req0_o,
  output logic              clk_inv0_o,
  output logic              clk_inv1_o,
  output logic [3:0]        turn_req1_o,
  output logic              src_sel_o,
  output logic              base_dir_o,
  output logic              clk_en_o,
  output logic              role_o,
  output logic [7:0]        test_din_o,
  output logic              test_en_o,
  output logic              test_clk_o,
  output logic              test_clr_o
);

  localparam int STAT_PAD = 32 - TDO_W;

  logic [NUM_WORDS-1:0]             addr_hit;
  logic [NUM_WORDS-1:0]             wr_hit;
  logic [NUM_WORDS-1:0][HALF_W-1:0] word_q;
  logic                             status_hit;
  logic [TDO_W-1:0]                 status_q;

  assign status_hit = (16'(bus_addr) == OFS_STATUS);

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    assign addr_hit[gi] = (16'(bus_addr) == word_offset(gi));
    assign wr_hit[gi]   = bus_wr && addr_hit[gi];

    phy_ctrl_bank_word #(
      .IMPL (word_impl(gi)),
      .RSTV (word_reset(gi))
    ) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit[gi]),
      .wdata  (bus_wdata),
      .q      (word_q[gi])
    );
  end

  phy_ctrl_bank_sync #(.WIDTH(TDO_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (test_dout_i),
    .q     (status_q)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (addr_hit[i]) bus_rdata = {16'h0000, word_q[i]};
    if (status_hit) bus_rdata = {{STAT_PAD{1'b0}}, status_q};
  end

  // field fan-out
  assign rx_lane_en_o = word_q[IDX_LANE][3:0];
  assign force_rx_o   = word_q[IDX_LANE][7:4];
  assign force_stop_o = word_q[IDX_LANE][11:8];
  assign turn_dis_o   = word_q[IDX_LANE][15:12];
  assign turn_req0_o  = word_q[IDX_TURN0][3:0];
  assign clk_inv0_o   = word_q[IDX_TURN0][10];
  assign clk_inv1_o   = word_q[IDX_TURN0][11];
  assign turn_req1_o  = word_q[IDX_PORT1][3:0];
  assign src_sel_o    = word_q[IDX_PORT1][4];
  assign base_dir_o   = word_q[IDX_PORT1][5];
  assign clk_en_o     = word_q[IDX_PORT1][6];
  assign role_o       = word_q[IDX_PORT1][7];
  assign test_din_o   = word_q[IDX_TEST][7:0];
  assign test_en_o    = word_q[IDX_TEST][8];
  assign test_clk_o   = word_q[IDX_TEST][9];
  assign test_clr_o   = word_q[IDX_TEST][10];

  // cycles since reset, saturating, so the sync check never reaches before reset
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|addr_hit) |-> (bus_rdata[31:16] == 16'h0000));

  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !(|addr_hit)) |=> $stable(word_q));

  assert_sync_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (status_q == $past(test_dout_i, 2)));

  assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_hit, status_hit}));

endmodule

// File: tb/phy_ctrl_bank_tb.sv
module phy_ctrl_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  test_dout_i = '0;
  logic [3:0]  rx_lane_en_o, force_rx_o, force_stop_o, turn_dis_o;
  logic [3:0]  turn_req0_o, turn_req1_o;
  logic        clk_inv0_o, clk_inv1_o, src_sel_o, base_dir_o, clk_en_o, role_o;
  logic [7:0]  test_din_o;
  logic        test_en_o, test_clk_o, test_clr_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  phy_ctrl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .test_dout_i(test_dout_i),
    .rx_lane_en_o(rx_lane_en_o), .force_rx_o(force_rx_o),
    .force_stop_o(force_stop_o), .turn_dis_o(turn_dis_o),
    .turn_req0_o(turn_req0_o), .clk_inv0_o(clk_inv0_o), .clk_inv1_o(clk_inv1_o),
    .turn_req1_o(turn_req1_o), .src_sel_o(src_sel_o), .base_dir_o(base_dir_o),
    .clk_en_o(clk_en_o), .role_o(role_o), .test_din_o(test_din_o),
    .test_en_o(test_en_o), .test_clk_o(test_clk_o), .test_clr_o(test_clr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R7 lane", 16'h6254, 32'h0);
    rd_chk("R7 turn0", 16'h6224, 32'h0);
    rd_chk("R7 port1", 16'h6260, 32'h0);
    rd_chk("R7 test", 16'h6264, 32'h0000_0200);
    chk("R7 test_clk pin", {31'b0, test_clk_o}, 32'h1);
    chk("R7 lane pins", {16'b0, turn_dis_o, force_stop_o, force_rx_o, rx_lane_en_o}, 32'h0);
  endtask

  task automatic t_lane;
    wr(16'h6254, 32'hFFFF_A5C3);
    chk("R3 lane en", {28'b0, rx_lane_en_o}, 32'h3);
    chk("R3 force rx", {28'b0, force_rx_o}, 32'hC);
    chk("R3 force stop", {28'b0, force_stop_o}, 32'h5);
    chk("R3 turn dis", {28'b0, turn_dis_o}, 32'hA);
    // enable only bits 3:0 and 12, load zeros
    wr(16'h6254, 32'h100F_0000);
    rd_chk("R1 R2 lane partial", 16'h6254, 32'h0000_A5C0);
    wr(16'h6254, 32'h0000_FFFF);
    rd_chk("R2 zero mask", 16'h6254, 32'h0000_A5C0);
  endtask

  task automatic t_turn0;
    wr(16'h6224, 32'hFFFF_FFFF);
    rd_chk("R4 impl bits", 16'h6224, 32'h0000_0C0F);
    chk("R4 pins", {26'b0, clk_inv1_o, clk_inv0_o, turn_req0_o}, 32'h3F);
    wr(16'h6224, 32'h0400_0000);
    chk("R2 inv0 cleared only", {26'b0, clk_inv1_o, clk_inv0_o, turn_req0_o}, 32'h2F);
  endtask

  task automatic t_port1;
    wr(16'h6260, 32'hFFFF_FFA6);
    rd_chk("R5 word", 16'h6260, 32'h0000_00A6);
    chk("R5 pins", {24'b0, role_o, clk_en_o, base_dir_o, src_sel_o, turn_req1_o}, 32'hA6);
  endtask

  task automatic t_test;
    wr(16'h6264, 32'hFFFF_055A);
    chk("R6 pins", {20'b0, test_clr_o, test_clk_o, test_en_o, test_din_o}, 32'h55A);
    wr(16'h6264, 32'h0200_0200);
    rd_chk("R6 R1 test clk only", 16'h6264, 32'h0000_075A);
    rd_chk("R8 upper zero", 16'h6264, 32'h0000_075A);
  endtask

  task automatic t_unmapped;
    wr(16'h6228, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped read", 16'h6228, 32'h0);
    rd_chk("R9 lane kept", 16'h6254, 32'h0000_A5C0);
    rd_chk("R9 turn0 kept", 16'h6224, 32'h0000_080F);
    rd_chk("R9 port1 kept", 16'h6260, 32'h0000_00A6);
    rd_chk("R9 test kept", 16'h6264, 32'h0000_075A);
  endtask

  task automatic t_status;
    @(negedge clk);
    test_dout_i = 8'h3C;
    bus_addr = 16'hE2A4;
    @(negedge clk);
    chk("R10 one edge old", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R10 two edges new", bus_rdata, 32'h0000_003C);
    wr(16'hE2A4, 32'hFFFF_FFFF);
    rd_chk("R10 read only", 16'hE2A4, 32'h0000_003C);
    rd_chk("R10 write left words", 16'h6254, 32'h0000_A5C0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lane();
    t_turn0();
    t_port1();
    t_test();
    t_unmapped();
    t_status();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule